// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a word-addressed countdown timer for a processor core. Software sees four registers: a control word, a period, a prescale value and the live count. It sets a power bit and a run bit in the control word. While both are set, a prescale counter divides the clock. Each prescaled tick lowers the count by one. When the count runs out, the timer raises a one-cycle interrupt request and latches a status bit in the control word. It then either reloads the count from the period register or stops by clearing its run bit.

Register writes arrive as single-cycle strobes with an address and a data word. Reads return data combinationally for whatever address is presented. A write to the count register takes effect on the next clock edge and overrides any counting in progress. This lets software re-arm or shorten an interval at any time. The status bit stays set until software writes a 1 to it.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: Word registers sit at byte offsets 0x0 (control), 0x4 (period), 0x8 (prescale) and 0xC (count). Control bit 0 is power, bit 1 is run, bit 2 is auto-reload and bit 3 is the expiry status; bits above 3 read zero. A write to any other address, including a misaligned one, changes nothing, and a read of one returns zero.
- R3: The count and the prescale divider advance only while power and run are both set. Otherwise the count holds and no interrupt is raised.
- R4: The period register keeps its written value across starting, stopping and expiry, and changes only when it is written.
- R5: A tick that finds the count at 1 or 0 is an expiry. It drives the interrupt output high for exactly the next cycle and sets control bit 3.
- R6: With auto-reload clear, an expiry leaves the count at 0 and clears the run bit, so control reads 0x9 when power was set.
- R7: With auto-reload set, an expiry loads the count from the period register and the run bit stays set.
- R8: With prescale value S, ticks occur on every (S+1)th active clock. The first tick falls on the (S+1)th clock edge after the run bit is set, so S=0 gives one tick per clock.
- R9: Writing control with bit 3 set clears the status bit. Writing 0 to bit 3 leaves it alone. An expiry in the same cycle as a clearing write leaves the status bit set.
- R10: A count write loads the new value at the next edge, ahead of any tick, and cancels an expiry in that same cycle.
- R11: Writing 0 to control stops the timer fully. The count then holds, and a later restart waits a full prescale interval before the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register accessed |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
On every cycle, the assertions check the following:
- no tick, count change or interrupt happens while the timer is idle;
- an interrupt always comes with the status bit set;
- the period only changes on a write;
- an expiry either stops the run bit or reloads the count from the period, according to the reload bit.

Some behaviours show only in the bench's scenarios, where a reference model follows every cycle:
- the exact tick spacing for a given prescale value;
- where the first expiry falls after a start;
- the write-one-to-clear status behaviour;
- a count write overriding a run in progress;
- readback of each register against the address map.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // word index of each register (byte offset divided by 4)
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_PERIOD = 2'd1,
      SEL_SCALE  = 2'd2,
      SEL_COUNT  = 2'd3
   } reg_sel_e;

   localparam int B_PWR    = 0;
   localparam int B_RUN    = 1;
   localparam int B_RELOAD = 2;
   localparam int B_FLAG   = 3;
   localparam int CTRL_W   = 4;

   typedef struct packed {
      logic flag;
      logic reload;
      logic run;
      logic pwr;
   } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
   import tmr_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int CNT_W        = 32,
   parameter int SCALE_W      = 32,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ctrl,
   input  logic               wr_period,
   input  logic               wr_scale,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               expire,
   output ctrl_t              ctrl,
   output logic [CNT_W-1:0]   period,
   output logic [SCALE_W-1:0] scale
);
   // control word: software fields plus sticky status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl.pwr    <= wdata[B_PWR];
            ctrl.run    <= wdata[B_RUN];
            ctrl.reload <= wdata[B_RELOAD];
         end else if (expire && !ctrl.reload) begin
            ctrl.run <= 1'b0;
         end
         if (expire)
            ctrl.flag <= 1'b1;
         else if (wr_ctrl && wdata[B_FLAG])
            ctrl.flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         period <= '0;
      else if (wr_period)
         period <= wdata[CNT_W-1:0];
   end

   generate
      if (HAS_PRESCALE) begin : g_scale_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               scale <= '0;
            else if (wr_scale)
               scale <= wdata[SCALE_W-1:0];
         end
      end else begin : g_scale_none
         assign scale = '0;
      end
   endgenerate
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SCALE_W      = 32,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [SCALE_W-1:0] scale,
   output logic               tick
);
   generate
      if (HAS_PRESCALE) begin : g_div
         logic [SCALE_W-1:0] div_q;
         logic               div_zero;
         assign div_zero = (div_q == '0);
         assign tick     = active && div_zero;
         // idle: keep the divider primed so a restart waits a full interval
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (!active || div_zero)
               div_q <= scale;
            else
               div_q <= div_q - 1'b1;
         end
      end else begin : g_direct
         assign tick = active;
      end
   endgenerate
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_count,
   input  logic [CNT_W-1:0] wr_value,
   input  logic             reload_en,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             expire,
   output logic             irq
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   // a software write wins over the tick and cancels the expiry
   assign expire = tick && !wr_count && (count <= LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= expire;
         if (wr_count)
            count <= wr_value;
         else if (expire)
            count <= reload_en ? period : '0;
         else if (tick)
            count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter int CNT_W        = 32,
   parameter int SCALE_W      = 32,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int WORD_LSB = 2;
   localparam int MAP_BITS = WORD_LSB + 2;

   generate
      if (ADDR_W < MAP_BITS) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("DATA_W narrower than the control word");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..DATA_W");
      end
      if (SCALE_W < 1 || SCALE_W > DATA_W) begin : g_bad_scale
         $error("SCALE_W must lie in 1..DATA_W");
      end
   endgenerate

   reg_sel_e           sel;
   logic               hit;
   logic               wr_ctrl, wr_period, wr_scale, wr_count;
   ctrl_t              ctrl;
   logic [CNT_W-1:0]   period;
   logic [CNT_W-1:0]   count;
   logic [SCALE_W-1:0] scale;
   logic               active;
   logic               tick;
   logic               expire;

   assign sel = reg_sel_e'(addr[WORD_LSB+1:WORD_LSB]);

   generate
      if (ADDR_W > MAP_BITS) begin : g_hi_dec
         assign hit = (addr[ADDR_W-1:MAP_BITS] == '0) && (addr[WORD_LSB-1:0] == '0);
      end else begin : g_lo_dec
         assign hit = (addr[WORD_LSB-1:0] == '0);
      end
   endgenerate

   assign wr_ctrl   = wr_en && hit && (sel == SEL_CTRL);
   assign wr_period = wr_en && hit && (sel == SEL_PERIOD);
   assign wr_scale  = wr_en && hit && (sel == SEL_SCALE);
   assign wr_count  = wr_en && hit && (sel == SEL_COUNT);

   assign active = ctrl.pwr && ctrl.run;

   tmr_ctrl_regs #(
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .SCALE_W     (SCALE_W),
      .HAS_PRESCALE(HAS_PRESCALE)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_period(wr_period),
      .wr_scale (wr_scale),
      .wdata    (wdata),
      .expire   (expire),
      .ctrl     (ctrl),
      .period   (period),
      .scale    (scale)
   );

   tmr_prescaler #(
      .SCALE_W     (SCALE_W),
      .HAS_PRESCALE(HAS_PRESCALE)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .active(active),
      .scale (scale),
      .tick  (tick)
   );

   tmr_downcount #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_count (wr_count),
      .wr_value (wdata[CNT_W-1:0]),
      .reload_en(ctrl.reload),
      .period   (period),
      .count    (count),
      .expire   (expire),
      .irq      (irq)
   );

   always_comb begin
      rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_CTRL:   rdata[CTRL_W-1:0]  = ctrl;
            SEL_PERIOD: rdata[CNT_W-1:0]   = period;
            SEL_SCALE:  rdata[SCALE_W-1:0] = scale;
            SEL_COUNT:  rdata[CNT_W-1:0]   = count;
         endcase
      end
   end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic             active,
   input logic             tick,
   input logic             expire,
   input logic             wr_ctrl,
   input logic             wr_period,
   input logic             wr_count,
   input ctrl_t            ctrl,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] count
);
   AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !irq); // R3
   AST_IDLE_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !wr_count) |=> $stable(count)); // R3
   AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_period |=> $stable(period)); // R4
   AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctrl.flag); // R5
   AST_STOP_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl.reload && !wr_ctrl) |=> !ctrl.run); // R6
   AST_RELOAD_FROM_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl.reload) |=> (count == $past(period))); // R7
   AST_TICK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> active); // R8
endmodule

bind core_tick_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq      (irq),
   .active   (active),
   .tick     (tick),
   .expire   (expire),
   .wr_ctrl  (wr_ctrl),
   .wr_period(wr_period),
   .wr_count (wr_count),
   .ctrl     (ctrl),
   .period   (period),
   .count    (count)
);

// File: tb/core_tick_timer_test.sv
module core_tick_timer_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_SCL = 4'h8, A_CNT = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   core_tick_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // behavioural reference model
   bit          m_pwr, m_run, m_rel, m_flag, m_irq;
   logic [31:0] m_per, m_scl, m_div, m_cnt;

   function automatic logic [31:0] m_read(input logic [3:0] a);
      case (a)
         A_CTRL:  return {28'd0, m_flag, m_rel, m_run, m_pwr};
         A_PER:   return m_per;
         A_SCL:   return m_scl;
         A_CNT:   return m_cnt;
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_pwr, m_run, m_rel, m_flag, m_irq} = '0;
         m_per = 0; m_scl = 0; m_div = 0; m_cnt = 0;
      end else begin
         bit go, tk, ex, wc;
         logic [31:0] n_div, n_cnt;
         bit n_run, n_flag;
         go = m_pwr && m_run;
         tk = go && (m_div == 0);
         wc = wr_en && addr == A_CNT;
         ex = tk && !wc && (m_cnt <= 1);
         n_div = (!go || m_div == 0) ? m_scl : m_div - 1;
         if (wc) n_cnt = wdata;
         else if (ex) n_cnt = m_rel ? m_per : 0;
         else if (tk) n_cnt = m_cnt - 1;
         else n_cnt = m_cnt;
         n_run = m_run; n_flag = m_flag;
         if (wr_en && addr == A_CTRL) begin
            n_run = wdata[1];
            m_pwr = wdata[0];
            if (wdata[3]) n_flag = 0;
         end else if (ex && !m_rel) n_run = 0;
         if (ex) n_flag = 1;
         if (wr_en && addr == A_CTRL) m_rel = wdata[2];
         if (wr_en && addr == A_PER) m_per = wdata;
         if (wr_en && addr == A_SCL) m_scl = wdata;
         m_run = n_run; m_flag = n_flag; m_div = n_div; m_cnt = n_cnt; m_irq = ex;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #2;
         chk("R5 irq vs model", {31'd0, irq}, {31'd0, m_irq});
         chk("R2 rdata vs model", rdata, m_read(addr));
         if (irq) irq_seen++;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int base;
      idle(2);
      #1;
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      rd("R1 ctrl after reset", A_CTRL, 0);
      rd("R1 count after reset", A_CNT, 0);
      rst_n = 1'b1;
      idle(1);

      // power only, no counting
      wr(A_CTRL, 32'h1);
      wr(A_PER, 32'h50);
      wr(A_CNT, 32'h13);
      wr(A_SCL, 32'h0);
      rd("R2 period readback", A_PER, 32'h50);
      rd("R2 ctrl power only", A_CTRL, 32'h1);
      idle(10);
      rd("R3 power without run holds count", A_CNT, 32'h13);
      wr(4'h6, 32'hDEAD);
      rd("R2 misaligned write ignored", A_PER, 32'h50);
      rd("R2 unmapped read zero", 4'h6, 0);

      // single shot run, scale 0
      base = irq_seen;
      wr(A_CTRL, 32'h3);
      idle(30);
      rd("R6 ctrl after one-shot expiry", A_CTRL, 32'h9);
      rd("R6 count after one-shot expiry", A_CNT, 0);
      chk("R5 one irq pulse", irq_seen - base, 1);
      rd("R4 period held after run", A_PER, 32'h50);
      wr(A_CTRL, 32'h1);
      rd("R9 zero in bit3 keeps status", A_CTRL, 32'h9);
      wr(A_CTRL, 32'h8);
      rd("R9 write one clears status", A_CTRL, 32'h0);

      // prescale timing: count 5, scale 2, no reload
      wr(A_SCL, 32'h2);
      wr(A_CNT, 32'h5);
      wr(A_CTRL, 32'h3);
      idle(14);
      #2 chk("R8 no irq before 15th edge", {31'd0, irq}, 0);
      idle(1);
      #2 chk("R8 irq after 15th edge", {31'd0, irq}, 1);
      idle(1);
      #2 chk("R5 irq lasts one cycle", {31'd0, irq}, 0);

      // auto reload run
      wr(A_CTRL, 32'h8);
      wr(A_CTRL, 32'h1);
      wr(A_PER, 32'h15);
      wr(A_CNT, 32'h13);
      wr(A_SCL, 32'h2);
      base = irq_seen;
      wr(A_CTRL, 32'h7);
      idle(200);
      chk("R7 several expiries with reload", (irq_seen - base >= 3) ? 1 : 0, 1);
      rd("R7 run stays set", A_CTRL, m_read(A_CTRL));
      chk("R7 run bit still set", {31'd0, rdata[1]}, 1);
      rd("R4 period held during reload", A_PER, 32'h15);
      wr(A_CNT, 32'h100);
      rd("R10 count write takes effect", A_CNT, 32'h100);

      // stop fully
      wr(A_CTRL, 32'h0);
      idle(1);
      rd("R11 stop holds count", A_CNT, m_read(A_CNT));
      base = int'(rdata);
      idle(20);
      rd("R11 count still held", A_CNT, base);
      chk("R11 model agrees", m_read(A_CNT), base);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule